// File: doc/BRIEF.md
# DRAM Strobe Decoder and Refresh Counter

This block is a synthesizable, device-side model of an asynchronous page-mode DRAM with two byte lanes. A fast free-running clock oversamples the memory pins: the row strobe, the lower and upper column strobes, write enable, output enable, the 9-bit multiplexed address and the 16-bit write data. Every pin first passes through a two-stage synchroniser. Edge detection then runs on the synchronised copies, so every strobe edge is seen in a fixed order.

The two column strobes are merged into one internal column strobe. It goes active on the first lane strobe to fall and goes inactive only when the last one rises. The row strobe falling edge latches the row. Each fall of the internal column strobe latches a new column in the open row, which gives page-mode access. Write data is captured at the later of the write-enable fall and the column-strobe fall. A row strobe that falls while the column strobe is already low starts a column-first refresh. That cycle takes its row from an internal counter, which then steps through all rows.

Every row strobe fall marks the row it used as refreshed. A per-row tracker raises a sticky error when any row goes a whole window without being marked. The storage array is byte-writable, and its depth is set by parameters so that only the low row and column bits index it.

Top module: `dram_strobe_model`

## Requirements
- R1: The internal column strobe is active while either lane strobe is low and inactive only once both are high. A read that starts on one lane keeps `rdata_oe` high until the last lane strobe rises.
- R2: The lower strobe gates bits 7:0 and the upper strobe gates bits 15:8, both for writes and for read data. Read data in a lane whose strobe is high reads as 0.
- R3: A row strobe fall latches `addr` as the open row, shown on `open_row`. Each internal column strobe fall while the row is open latches `addr` as the column, so several columns can be accessed in one row.
- R4: A write stores `wdata` at the later of the write-enable fall and the column-strobe fall. If write enable falls first (early write), the store happens at the strobe fall. If the strobe falls first (late write), the store happens at the write-enable fall, using the data present then.
- R5: A column access with write enable high is a read and leaves the array unchanged. `cyc_kind` encodes 0 idle, 1 read, 2 write, 3 row-only refresh, 4 column-first refresh, and holds its value after the cycle ends.
- R6: A row strobe fall while the column strobe is already low is a column-first refresh. It uses the refresh counter as the row, writes nothing whatever the write enable does, and advances the counter. The counter starts at 0 after reset and wraps after 512 rows.
- R7: A row strobe cycle with no column strobe is a row-only refresh (`cyc_kind` 3) of the row given on `addr`.
- R8: `retention_err` becomes 1, and stays 1 until reset, at the end of any WINDOW-cycle window in which some row received no row strobe cycle. It stays 0 if every row was refreshed within the window.
- R9: `rdata_oe` is high only while output enable is low, the internal column strobe is low, write enable is high and a column of a normal open row has been latched. `rdata` is 0 whenever `rdata_oe` is low.
- R10: After reset, `rdata_oe`, `rdata`, `cyc_kind` and `retention_err` are 0 and the refresh counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Row strobe, active low |
| lo_stb_n | input | 1 | Lower-byte column strobe, active low |
| hi_stb_n | input | 1 | Upper-byte column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, lane-masked |
| rdata_oe | output | 1 | Read data valid / drive enable |
| cyc_kind | output | 3 | Kind of the latest cycle |
| open_row | output | ROW_W | Row latched by the latest row strobe fall |
| retention_err | output | 1 | Sticky refresh-window violation |

## Verification
The assertions assume that each pin level is held for at least two clocks, so that every synchronised edge is seen on its own sample. They also assume that the row strobe and the internal column strobe never fall on the same sample, and that the address is stable around each strobe fall. The bench changes one pin group at a time on the falling clock edge and then waits three or four cycles before the next change or check. This keeps every strobe edge separate and ordered, and keeps address and data settled before the strobe that captures them.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic [2:0] {
    CK_IDLE     = 3'd0,
    CK_READ     = 3'd1,
    CK_WRITE    = 3'd2,
    CK_ROWONLY  = 3'd3,
    CK_COLFIRST = 3'd4
  } cyc_kind_e;

  // Internal column strobe (active low): low while either lane strobe is low (R1).
  function automatic logic merge_col_n(input logic lo_n, input logic hi_n);
    return lo_n & hi_n;
  endfunction

  // Lane enables {upper, lower} from the two active-low lane strobes (R2).
  function automatic logic [1:0] lane_enables(input logic lo_n, input logic hi_n);
    return {~hi_n, ~lo_n};
  endfunction

endpackage

// File: rtl/dsm_sync.sv
module dsm_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dsm_strobe_dec.sv
module dsm_strobe_dec import dsm_pkg::*; #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_rs,
  input  logic             s_lo,
  input  logic             s_hi,
  input  logic             s_we,
  input  logic [ROW_W-1:0] s_addr,
  output logic             s_ics,
  output logic             row_fall,
  output logic             ics_fall,
  output logic             we_fall,
  output logic             colfirst,
  output logic             row_open,
  output logic             ref_mode,
  output logic             col_valid,
  output logic [ROW_W-1:0] row_q,
  output logic [ROW_W-1:0] col_q,
  output logic [ROW_W-1:0] ref_ctr,
  output logic             wr_evt,
  output logic [ROW_W-1:0] wr_col,
  output logic [1:0]       lanes,
  output logic             touch_vld,
  output logic [ROW_W-1:0] touch_row,
  output cyc_kind_e        kind
);
  logic p_rs, p_ics, p_we;
  logic row_rise, ics_rise;

  assign s_ics    = merge_col_n(s_lo, s_hi);
  assign lanes    = lane_enables(s_lo, s_hi);
  assign row_fall = p_rs & ~s_rs;
  assign row_rise = ~p_rs & s_rs;
  assign ics_fall = p_ics & ~s_ics;
  assign ics_rise = ~p_ics & s_ics;
  assign we_fall  = p_we & ~s_we;
  assign colfirst = row_fall & ~p_ics;

  // Capture at the later of the two falls (R4).
  assign wr_evt    = row_open & ~s_ics & ~s_we & (we_fall | ics_fall);
  assign wr_col    = ics_fall ? s_addr : col_q;
  assign touch_vld = row_fall;
  assign touch_row = colfirst ? ref_ctr : s_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rs      <= 1'b1;
      p_ics     <= 1'b1;
      p_we      <= 1'b1;
      row_open  <= 1'b0;
      ref_mode  <= 1'b0;
      col_valid <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      ref_ctr   <= '0;
      kind      <= CK_IDLE;
    end else begin
      p_rs  <= s_rs;
      p_ics <= s_ics;
      p_we  <= s_we;
      if (row_fall) begin
        row_q    <= touch_row;
        row_open <= ~colfirst;
        ref_mode <= colfirst;
        kind     <= colfirst ? CK_COLFIRST : CK_ROWONLY;
        if (colfirst) ref_ctr <= ref_ctr + 1'b1;
      end else if (row_rise) begin
        row_open  <= 1'b0;
        ref_mode  <= 1'b0;
        col_valid <= 1'b0;
      end
      if (row_open && ics_fall) begin
        col_q     <= s_addr;
        col_valid <= 1'b1;
        kind      <= s_we ? CK_READ : CK_WRITE;
      end else if (ics_rise) begin
        col_valid <= 1'b0;
      end
      if (wr_evt && !ics_fall) kind <= CK_WRITE;
    end
  end
endmodule

// File: rtl/dsm_array.sv
module dsm_array #(
  parameter int ROW_W    = 9,
  parameter int DATA_W   = 16,
  parameter int AR_BITS  = 2,
  parameter int AC_BITS  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [1:0]        lanes,
  input  logic [ROW_W-1:0]  w_row,
  input  logic [ROW_W-1:0]  w_col,
  input  logic [DATA_W-1:0] w_data,
  input  logic [ROW_W-1:0]  r_row,
  input  logic [ROW_W-1:0]  r_col,
  output logic [DATA_W-1:0] r_data
);
  localparam int IDX_W  = AR_BITS + AC_BITS;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [IDX_W-1:0] word_idx(input logic [ROW_W-1:0] r,
                                                input logic [ROW_W-1:0] c);
    return {r[AR_BITS-1:0], c[AC_BITS-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < 2; b++) begin
        if (lanes[b])
          mem[word_idx(w_row, w_col)][b*LANE_W +: LANE_W] <= w_data[b*LANE_W +: LANE_W];
      end
    end
  end

  assign r_data = mem[word_idx(r_row, r_col)];
endmodule

// File: rtl/dsm_ret_tracker.sv
module dsm_ret_tracker #(
  parameter int ROW_W  = 9,
  parameter int WINDOW = 400000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_vld,
  input  logic [ROW_W-1:0] touch_row,
  output logic             win_end,
  output logic             err
);
  localparam int            ROWS = 1 << ROW_W;
  localparam int            CW   = $clog2(WINDOW);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [ROWS-1:0] seen_q;
  logic [ROWS-1:0] hit;
  logic [CW-1:0]   cnt_q;

  assign hit     = touch_vld ? (ROWS'(1) << touch_row) : '0;
  assign win_end = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      cnt_q  <= '0;
      err    <= 1'b0;
    end else if (win_end) begin
      cnt_q  <= '0;
      err    <= err | ~&(seen_q | hit);
      seen_q <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      seen_q <= seen_q | hit;
    end
  end
endmodule

// File: rtl/dram_strobe_model.sv
module dram_strobe_model import dsm_pkg::*; #(
  parameter int ROW_W        = 9,
  parameter int DATA_W       = 16,
  parameter int ARR_ROW_BITS = 2,
  parameter int ARR_COL_BITS = 4,
  parameter int WINDOW       = 400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb_n,
  input  logic              lo_stb_n,
  input  logic              hi_stb_n,
  input  logic              wr_en_n,
  input  logic              out_en_n,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic [2:0]        cyc_kind,
  output logic [ROW_W-1:0]  open_row,
  output logic              retention_err
);
  localparam int               PIN_W    = 5 + ROW_W + DATA_W;
  localparam int               LANE_W   = DATA_W / 2;
  localparam logic [PIN_W-1:0] PIN_IDLE = {5'b11111, {(ROW_W + DATA_W){1'b0}}};

  logic [PIN_W-1:0]  pins_q;
  logic              s_rs, s_lo, s_hi, s_we, s_oe;
  logic [ROW_W-1:0]  s_addr;
  logic [DATA_W-1:0] s_din;

  dsm_sync #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({row_stb_n, lo_stb_n, hi_stb_n, wr_en_n, out_en_n, addr, wdata}),
    .q(pins_q)
  );
  assign {s_rs, s_lo, s_hi, s_we, s_oe, s_addr, s_din} = pins_q;

  // Named internal events, also used by the bound checker.
  logic             s_ics, row_fall, ics_fall, we_fall, colfirst;
  logic             row_open, ref_mode, col_valid, wr_evt, touch_vld, win_end;
  logic [ROW_W-1:0] row_q, col_q, ref_ctr, wr_col, touch_row;
  logic [1:0]       lanes;
  cyc_kind_e        kind;

  dsm_strobe_dec #(.ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .s_rs(s_rs), .s_lo(s_lo), .s_hi(s_hi), .s_we(s_we), .s_addr(s_addr),
    .s_ics(s_ics), .row_fall(row_fall), .ics_fall(ics_fall), .we_fall(we_fall),
    .colfirst(colfirst), .row_open(row_open), .ref_mode(ref_mode),
    .col_valid(col_valid), .row_q(row_q), .col_q(col_q), .ref_ctr(ref_ctr),
    .wr_evt(wr_evt), .wr_col(wr_col), .lanes(lanes),
    .touch_vld(touch_vld), .touch_row(touch_row), .kind(kind)
  );

  logic [DATA_W-1:0] arr_rd;

  dsm_array #(.ROW_W(ROW_W), .DATA_W(DATA_W),
              .AR_BITS(ARR_ROW_BITS), .AC_BITS(ARR_COL_BITS)) u_arr (
    .clk(clk), .we(wr_evt), .lanes(lanes),
    .w_row(row_q), .w_col(wr_col), .w_data(s_din),
    .r_row(row_q), .r_col(col_q), .r_data(arr_rd)
  );

  dsm_ret_tracker #(.ROW_W(ROW_W), .WINDOW(WINDOW)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .touch_vld(touch_vld), .touch_row(touch_row),
    .win_end(win_end), .err(retention_err)
  );

  logic [DATA_W-1:0] lane_bits;
  assign lane_bits = {{LANE_W{lanes[1]}}, {LANE_W{lanes[0]}}};

  assign rdata_oe = col_valid & ~ref_mode & ~s_ics & s_we & ~s_oe;
  assign rdata    = rdata_oe ? (arr_rd & lane_bits) : '0;
  assign cyc_kind = kind;
  assign open_row = row_q;
endmodule

// File: rtl/dsm_checker.sv
module dsm_checker #(
  parameter int ROW_W  = 9,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ics,
  input logic              s_we,
  input logic              s_oe,
  input logic              rdata_oe,
  input logic [DATA_W-1:0] rdata,
  input logic              row_fall,
  input logic              ics_fall,
  input logic              we_fall,
  input logic              colfirst,
  input logic              ref_mode,
  input logic              wr_evt,
  input logic [1:0]        lanes,
  input logic [ROW_W-1:0]  ref_ctr,
  input logic [ROW_W-1:0]  open_row,
  input logic              err
);
  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0);

  p_drive_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!s_oe && s_we && !s_ics));

  p_drive_needs_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> lanes != 2'b00);

  p_write_has_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> lanes != 2'b00);

  p_write_at_later_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> (we_fall || ics_fall));

  p_no_write_in_refresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_mode |-> !wr_evt);

  p_ctr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    colfirst |=> ref_ctr == ROW_W'($past(ref_ctr) + 1'b1));

  p_ctr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !colfirst |=> $stable(ref_ctr));

  p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !row_fall |=> $stable(open_row));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind dram_strobe_model dsm_checker #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_dsm_chk (
  .clk(clk), .rst_n(rst_n), .s_ics(s_ics), .s_we(s_we), .s_oe(s_oe),
  .rdata_oe(rdata_oe), .rdata(rdata), .row_fall(row_fall), .ics_fall(ics_fall),
  .we_fall(we_fall), .colfirst(colfirst), .ref_mode(ref_mode), .wr_evt(wr_evt),
  .lanes(lanes), .ref_ctr(ref_ctr), .open_row(open_row), .err(retention_err)
);

// File: tb/test_dram_strobe_model.sv
module test_dram_strobe_model;
  localparam int ROW_W = 9;
  localparam int DW    = 16;
  localparam int WIN   = 8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rs_n = 1'b1, lo_n = 1'b1, hi_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ROW_W-1:0] addr = '0;
  logic [DW-1:0]    din = '0;
  logic [DW-1:0]    rdata;
  logic             rdata_oe, ret_err;
  logic [2:0]       kind;
  logic [ROW_W-1:0] orow;

  int n_chk = 0, n_bad = 0;
  int unsigned cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_strobe_model #(.ROW_W(ROW_W), .DATA_W(DW), .WINDOW(WIN)) i_dram_strobe_model (
    .clk(clk), .rst_n(rst_n), .row_stb_n(rs_n), .lo_stb_n(lo_n), .hi_stb_n(hi_n),
    .wr_en_n(we_n), .out_en_n(oe_n), .addr(addr), .wdata(din),
    .rdata(rdata), .rdata_oe(rdata_oe), .cyc_kind(kind), .open_row(orow),
    .retention_err(ret_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rs_n = 1; lo_n = 1; hi_n = 1; we_n = 1; oe_n = 1;
    wt(3);
    rst_n = 1'b1;
  endtask

  task automatic colfirst_refresh(input int gap);
    lo_n = 0; hi_n = 0; wt(gap);
    rs_n = 0; wt(gap);
    rs_n = 1; wt(gap);
    lo_n = 1; hi_n = 1; wt(gap);
  endtask

  task automatic t_reset_state();
    wt(4);
    chk("R10 rdata_oe", 32'(rdata_oe), 0);
    chk("R10 rdata", 32'(rdata), 0);
    chk("R10 kind", 32'(kind), 0);
    chk("R10 err", 32'(ret_err), 0);
  endtask

  task automatic t_retention_miss();
    int unsigned t0 = cyc;
    while (cyc - t0 < WIN - 100) wt(1);
    chk("R8 no err inside first window", 32'(ret_err), 0);
    while (cyc - t0 < WIN + 100) wt(1);
    chk("R8 err after window with no refresh", 32'(ret_err), 1);
    wt(50);
    chk("R8 err sticky", 32'(ret_err), 1);
  endtask

  task automatic t_sweep();
    int unsigned t0 = cyc;
    for (int r = 0; r < 512; r++) colfirst_refresh(3);
    while (cyc - t0 < WIN + 100) wt(1);
    chk("R8 full sweep keeps err low", 32'(ret_err), 0);
    lo_n = 0; hi_n = 0; wt(3); rs_n = 0; wt(4);
    chk("R6 counter wraps to 0", 32'(orow), 0);
    rs_n = 1; wt(3); lo_n = 1; hi_n = 1; wt(3);
  endtask

  task automatic t_write_early();
    addr = 9'd1; wt(4); rs_n = 0; wt(4);
    chk("R7 row strobe latches open row", 32'(orow), 1);
    we_n = 0; din = 16'hA5A5; addr = 9'd3; wt(4);
    lo_n = 0; hi_n = 0; wt(4);
    chk("R4 early write kind", 32'(kind), 2);
    lo_n = 1; hi_n = 1; wt(4);
    din = 16'h1234; addr = 9'd4; wt(4);
    lo_n = 0; hi_n = 0; wt(4);
    lo_n = 1; hi_n = 1; we_n = 1; wt(4);
    addr = 9'd3; oe_n = 0; wt(4);
    lo_n = 0; hi_n = 0; wt(4);
    chk("R3 page read col3 data", 32'(rdata), 32'hA5A5);
    chk("R5 read kind", 32'(kind), 1);
    chk("R9 drive on read", 32'(rdata_oe), 1);
    oe_n = 1; wt(4);
    chk("R9 OE high stops drive", 32'(rdata_oe), 0);
    chk("R9 bus zero when idle", 32'(rdata), 0);
    oe_n = 0; lo_n = 1; hi_n = 1; wt(4);
    addr = 9'd4; wt(4); lo_n = 0; hi_n = 0; wt(4);
    chk("R3 page read col4 data", 32'(rdata), 32'h1234);
    we_n = 0; wt(4);
    chk("R9 WE low stops drive", 32'(rdata_oe), 0);
    we_n = 1; lo_n = 1; hi_n = 1; oe_n = 1; wt(4);
    rs_n = 1; wt(4);
  endtask

  task automatic t_late_write();
    addr = 9'd2; wt(4); rs_n = 0; wt(4);
    din = 16'h1111; addr = 9'd5; wt(4);
    lo_n = 0; hi_n = 0; wt(4);
    chk("R5 strobe with WE high is read", 32'(kind), 1);
    din = 16'hBEEF; wt(4);
    we_n = 0; wt(4);
    chk("R4 late write kind", 32'(kind), 2);
    lo_n = 1; hi_n = 1; we_n = 1; wt(4);
    oe_n = 0; lo_n = 0; hi_n = 0; wt(4);
    chk("R4 late write data is data at WE fall", 32'(rdata), 32'hBEEF);
    lo_n = 1; hi_n = 1; oe_n = 1; wt(4);
    rs_n = 1; wt(4);
  endtask

  task automatic t_byte_lanes();
    addr = 9'd2; wt(4); rs_n = 0; wt(4);
    addr = 9'd6; din = 16'hFFFF; we_n = 0; wt(4);
    lo_n = 0; hi_n = 0; wt(4); lo_n = 1; hi_n = 1; wt(4);
    din = 16'h0000; wt(4);
    lo_n = 0; wt(4); lo_n = 1; wt(4);
    we_n = 1; oe_n = 0; wt(4);
    lo_n = 0; hi_n = 0; wt(4);
    chk("R2 lower-only write", 32'(rdata), 32'hFF00);
    lo_n = 1; hi_n = 1; wt(4);
    hi_n = 0; wt(4);
    chk("R2 upper-only read", 32'(rdata), 32'hFF00);
    hi_n = 1; wt(4);
    lo_n = 0; wt(4);
    chk("R2 lower-only read masks upper", 32'(rdata), 32'h0000);
    chk("R2 lower-only read drives", 32'(rdata_oe), 1);
    // R1: stagger the lanes
    hi_n = 0; wt(4);
    lo_n = 1; wt(4);
    chk("R1 strobe held by last lane", 32'(rdata_oe), 1);
    chk("R1 remaining lane data", 32'(rdata), 32'hFF00);
    hi_n = 1; wt(4);
    chk("R1 strobe ends when both high", 32'(rdata_oe), 0);
    oe_n = 1; rs_n = 1; wt(4);
  endtask

  task automatic t_row_only();
    addr = 9'h1A5; wt(4); rs_n = 0; wt(4);
    chk("R7 row-only open row", 32'(orow), 32'h1A5);
    rs_n = 1; wt(4);
    chk("R7 row-only kind", 32'(kind), 3);
    chk("R9 no drive in row-only", 32'(rdata_oe), 0);
  endtask

  task automatic t_colfirst();
    we_n = 0; din = 16'h0BAD; oe_n = 0;
    lo_n = 0; hi_n = 0; wt(4); rs_n = 0; wt(4);
    chk("R6 first refresh uses row 0", 32'(orow), 0);
    chk("R6 refresh kind", 32'(kind), 4);
    chk("R9 no drive during refresh", 32'(rdata_oe), 0);
    rs_n = 1; wt(4); lo_n = 1; hi_n = 1; wt(4);
    lo_n = 0; hi_n = 0; wt(4); rs_n = 0; wt(4);
    chk("R6 second refresh uses row 1", 32'(orow), 1);
    rs_n = 1; wt(4); lo_n = 1; hi_n = 1; we_n = 1; wt(4);
    addr = 9'd1; wt(4); rs_n = 0; wt(4);
    addr = 9'd3; wt(4); lo_n = 0; hi_n = 0; wt(4);
    chk("R6 refresh with WE low wrote nothing", 32'(rdata), 32'hA5A5);
    lo_n = 1; hi_n = 1; oe_n = 1; rs_n = 1; wt(4);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_retention_miss();
    do_reset();
    t_sweep();
    do_reset();
    t_write_early();
    t_late_write();
    t_byte_lanes();
    t_row_only();
    t_colfirst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule